// File: doc/BRIEF.md
# Three-Level Page Translation Unit

The block turns a 40-bit virtual address into a 32-bit physical address for pages of 8 KiB. A requester holds `req_i` with the address and access type until `ack_o` pulses. The unit then reports either a physical address or a fault with a cause code. An eight-entry fully associative buffer keeps recent page mappings, each with its write permission. When the buffer has no entry for a page, a sequential walker reads table entries one at a time through a word-read port. The walk starts at the root table frame supplied on `root_frame_i`.

Each table fills one 8 KiB page and holds 2048 entries of 32 bits, so every level takes 11 bits of the 27-bit virtual page number. Three levels are needed. The top level uses only 5 of its 11 index bits. An entry carries a frame number in bits 31:13, a present flag in bit 0, a write-permit flag in bit 1 and a user flag in bit 2 (carried but not checked). `flush_i` empties the buffer in one cycle.

Top module: `pt_xlate`

## Requirements
- R1: On a successful translation, `paddr_o` equals the 19-bit frame number of the final entry joined above `vaddr_i[12:0]`, and the offset is unchanged.
- R2: A walk issues exactly three reads, in level order. The first read uses the root frame with index `{6'b0, vaddr_i[39:35]}`, the second uses index `vaddr_i[34:24]` and the third uses index `vaddr_i[23:13]`. Each read address is `{frame, index, 2'b00}`, and the frame for the next level comes from bits 31:13 of the entry just read.
- R3: `mem_req_o` is high for exactly one cycle per read, and it does not rise again until `mem_valid_i` has returned that read's data.
- R4: An entry with bit 0 clear, at any level, ends the walk at once. The unit then reports `fault_o`=1 with `cause_o`=1 and makes no further reads.
- R5: A write access whose final entry has bit 1 clear faults with `cause_o`=2. A read of that page succeeds. Bit 1 of the upper-level entries has no effect.
- R6: A buffer hit makes no table read. `ack_o` is high after the second rising edge at which `req_i` is high.
- R7: A walk that faults leaves nothing in the buffer, so repeating the same request walks the tables again.
- R8: The buffer holds 8 pages and replaces them round robin. After 8 fills, a 9th fill evicts the oldest page, and the other 7 still hit.
- R9: After `flush_i` is pulsed, every page misses and is walked again.
- R10: While reset is held, `ack_o`, `fault_o` and `mem_req_o` are low.
- R11: `ack_o` is a single-cycle pulse per request. On success `fault_o`=0 and `cause_o`=0.
- R12: The buffer keeps the write permission, so a write that hits a page cached from a read-only final entry faults with `cause_o`=2 without any table read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate every buffer entry |
| root_frame_i | input | 19 | Frame number of the top-level table |
| req_i | input | 1 | Translation request, held until ack_o |
| vaddr_i | input | 40 | Virtual address |
| write_i | input | 1 | Access type: 1 write, 0 read |
| ack_o | output | 1 | Result valid pulse |
| fault_o | output | 1 | Translation failed |
| cause_o | output | 2 | 0 none, 1 not present, 2 write denied |
| paddr_o | output | 32 | Physical address |
| mem_req_o | output | 1 | Table read request, one cycle |
| mem_addr_o | output | 32 | Byte address of the table entry |
| mem_valid_i | input | 1 | Table read data valid |
| mem_rdata_i | input | 32 | Table entry read |

## Verification
The bench targets several corner cases:
- A present flag cleared at the middle level must stop the walk after two reads. A unit that ignored the flag would read a third entry and hand back a bogus frame.
- A read-only final entry first reached by a read must be cached with its permission. If the permission were dropped, a later write would hit and succeed silently.
- Denied and invalid walks repeated on the same page must walk the tables again, which exposes any unit that fills the buffer on a fault.
- A ninth distinct page must evict exactly the oldest one, and a flush must force fresh walks.
- Random addresses, random table contents and random memory latency check the translated address and the fault codes against a walk model.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;
  localparam int unsigned PTE_VALID = 0;
  localparam int unsigned PTE_WRITE = 1;
  localparam int unsigned PTE_USER  = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_INVALID = 2'd1,
    CAUSE_WRPROT  = 2'd2
  } cause_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_MREQ, S_MWAIT, S_DONE
  } walk_st_e;
endpackage

// File: rtl/pt_tlb.sv
module pt_tlb #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 27,
  parameter int unsigned PFN_W   = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] hit_pfn_o,
  output logic             hit_wr_o,
  input  logic             ins_i,
  input  logic [PFN_W-1:0] ins_pfn_i,
  input  logic             ins_wr_i
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] ent_wr;
  logic [PFN_W-1:0]   ent_pfn [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             v_q;
    logic             wr_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PFN_W-1:0] pfn_q;
    wire              sel = ins_i && (ptr_q == PTR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q   <= 1'b0;
        wr_q  <= 1'b0;
        vpn_q <= '0;
        pfn_q <= '0;
      end else if (flush_i) begin
        v_q <= 1'b0;
      end else if (sel) begin
        v_q   <= 1'b1;
        wr_q  <= ins_wr_i;
        vpn_q <= lk_vpn_i;
        pfn_q <= ins_pfn_i;
      end
    end

    assign match[g]   = v_q && (vpn_q == lk_vpn_i);
    assign ent_wr[g]  = wr_q;
    assign ent_pfn[g] = pfn_q;
  end

  always_comb begin
    hit_pfn_o = '0;
    hit_wr_o  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        hit_pfn_o = hit_pfn_o | ent_pfn[i];
        hit_wr_o  = hit_wr_o | ent_wr[i];
      end
    end
  end
  assign hit_o = |match;

  // round-robin victim pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (ins_i && !flush_i)
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  a_r8_no_duplicate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

// File: rtl/pt_walk.sv
module pt_walk
  import pt_xlate_pkg::*;
#(
  parameter int unsigned VA_W   = 40,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned OFF_W  = 13,
  parameter int unsigned PTE_W  = 32,
  parameter int unsigned LEVELS = 3,
  localparam int unsigned IDX_W = OFF_W - $clog2(PTE_W / 8),
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PFN_W = PA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             write_i,
  input  logic [PFN_W-1:0] root_i,
  output logic             ack_o,
  output logic             fault_o,
  output logic [1:0]       cause_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic [VPN_W-1:0] lk_vpn_o,
  input  logic             hit_i,
  input  logic [PFN_W-1:0] hit_pfn_i,
  input  logic             hit_wr_i,
  output logic             ins_o,
  output logic [PFN_W-1:0] ins_pfn_o,
  output logic             ins_wr_o
);
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [PFN_W-1:0] base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             fault_q;
  cause_e           cause_q;
  logic [PA_W-1:0]  pa_q;
  logic [IDX_W-1:0] idx;

  wire [VPN_W-1:0] vpn     = va_q[VA_W-1:OFF_W];
  wire             pte_v   = mem_rdata_i[PTE_VALID];
  wire             pte_wr  = mem_rdata_i[PTE_WRITE];
  wire [PFN_W-1:0] pte_pfn = mem_rdata_i[OFF_W +: PFN_W];
  wire             last    = (lvl_q == LVL_W'(LEVELS - 1));
  wire             deny    = wr_q && !pte_wr;
  wire             unused_pte_bits = ^mem_rdata_i[OFF_W-1:PTE_WRITE+1];

  // index slice for the current level; top level is zero-extended
  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++)
      if (lvl_q == LVL_W'(l)) idx = IDX_W'(vpn >> ((LEVELS - 1 - l) * IDX_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      pa_q    <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_i) begin
          va_q   <= vaddr_i;
          wr_q   <= write_i;
          base_q <= root_i;
          lvl_q  <= '0;
          st_q   <= S_LOOK;
        end
        S_LOOK: if (hit_i) begin
          fault_q <= wr_q && !hit_wr_i;
          cause_q <= (wr_q && !hit_wr_i) ? CAUSE_WRPROT : CAUSE_NONE;
          pa_q    <= {hit_pfn_i, va_q[OFF_W-1:0]};
          st_q    <= S_DONE;
        end else begin
          st_q <= S_MREQ;
        end
        S_MREQ: st_q <= S_MWAIT;
        S_MWAIT: if (mem_valid_i) begin
          if (!pte_v) begin
            fault_q <= 1'b1;
            cause_q <= CAUSE_INVALID;
            st_q    <= S_DONE;
          end else if (!last) begin
            base_q <= pte_pfn;
            lvl_q  <= lvl_q + 1'b1;
            st_q   <= S_MREQ;
          end else begin
            fault_q <= deny;
            cause_q <= deny ? CAUSE_WRPROT : CAUSE_NONE;
            pa_q    <= {pte_pfn, va_q[OFF_W-1:0]};
            st_q    <= S_DONE;
          end
        end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign ack_o      = (st_q == S_DONE);
  assign fault_o    = fault_q;
  assign cause_o    = cause_q;
  assign paddr_o    = pa_q;
  assign mem_req_o  = (st_q == S_MREQ);
  assign mem_addr_o = {base_q, idx, {(OFF_W - IDX_W){1'b0}}};
  assign lk_vpn_o   = vpn;
  assign ins_o      = (st_q == S_MWAIT) && mem_valid_i && pte_v && last && !deny;
  assign ins_pfn_o  = pte_pfn;
  assign ins_wr_o   = pte_wr;

  a_r3_single_cycle_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r3_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_MWAIT && !mem_valid_i) |=> !mem_req_o);
  a_r11_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r4_fault_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && fault_o) |-> (cause_o != 2'd0));
  a_r7_fill_only_on_success: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |=> (ack_o && !fault_o));
  a_r6_hit_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_LOOK && hit_i) |=> (ack_o && !mem_req_o));
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int unsigned VA_W    = 40,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 13,
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned LEVELS  = 3,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned VPN_W  = VA_W - OFF_W,
  localparam int unsigned PFN_W  = PA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [PFN_W-1:0] root_frame_i,
  input  logic             req_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             write_i,
  output logic             ack_o,
  output logic             fault_o,
  output logic [1:0]       cause_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_valid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  logic [VPN_W-1:0] lk_vpn;
  logic             hit, hit_wr, ins, ins_wr;
  logic [PFN_W-1:0] hit_pfn, ins_pfn;

  pt_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_tlb (
    .clk_i, .rst_ni, .flush_i,
    .lk_vpn_i (lk_vpn),
    .hit_o    (hit),
    .hit_pfn_o(hit_pfn),
    .hit_wr_o (hit_wr),
    .ins_i    (ins),
    .ins_pfn_i(ins_pfn),
    .ins_wr_i (ins_wr)
  );

  pt_walk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_W(PTE_W), .LEVELS(LEVELS)) i_walk (
    .clk_i, .rst_ni, .req_i, .vaddr_i, .write_i,
    .root_i     (root_frame_i),
    .ack_o, .fault_o, .cause_o, .paddr_o,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_rdata_i,
    .lk_vpn_o   (lk_vpn),
    .hit_i      (hit),
    .hit_pfn_i  (hit_pfn),
    .hit_wr_i   (hit_wr),
    .ins_o      (ins),
    .ins_pfn_o  (ins_pfn),
    .ins_wr_o   (ins_wr)
  );
endmodule

// File: tb/test_pt_xlate.sv
`timescale 1ns/1ps
module test_pt_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        flush_i;
  logic [18:0] root_frame_i;
  logic        req_i;
  logic [39:0] vaddr_i;
  logic        write_i;
  logic        ack_o, fault_o, mem_req_o, mem_valid_i;
  logic [1:0]  cause_o;
  logic [31:0] paddr_o, mem_addr_o, mem_rdata_i;

  always #2.5 clk_i = ~clk_i;

  pt_xlate i_pt_xlate (
    .clk_i, .rst_ni, .flush_i, .root_frame_i, .req_i, .vaddr_i, .write_i,
    .ack_o, .fault_o, .cause_o, .paddr_o,
    .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_rdata_i
  );

  int checks = 0, fails = 0, nrd = 0;
  logic [31:0] rd_log [16];
  bit          clean;
  logic [31:0] inv_a, ro_a0, ro_a1, resp_a;
  logic [31:0] r_pa, m_pa;
  logic        r_f, m_f;
  logic [1:0]  r_c, m_c;
  int          r_n, r_cyc, m_n;
  logic [31:0] m_a [3];

  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [31:0] h;
    logic [2:0]  fl;
    h = a * 32'h9E3779B1;
    h = h ^ (h >> 15);
    h = h * 32'h85EBCA6B;
    h = h ^ (h >> 13);
    if (clean) fl = {1'b0, !(a == ro_a0 || a == ro_a1), a != inv_a};
    else       fl = {h[7], h[5] | h[6], h[4:0] != 5'd0};
    return {h[31:13], 10'd0, fl};
  endfunction

  function automatic logic [39:0] pg(input int k, input int off);
    return {5'(k), 11'(k * 37 + 3), 11'(k * 91 + 17), 13'(off)};
  endfunction

  // reference walk from the requirements
  task automatic model(input logic [39:0] va, input logic wr);
    logic [18:0] base;
    logic [10:0] idx;
    logic [31:0] pte;
    base = root_frame_i; m_n = 0; m_f = 0; m_c = 0; m_pa = 0;
    for (int l = 0; l < 3; l++) begin
      idx = (l == 0) ? {6'd0, va[39:35]} : (l == 1) ? va[34:24] : va[23:13];
      m_a[l] = {base, idx, 2'b00};
      pte = pte_of(m_a[l]);
      m_n++;
      if (!pte[0]) begin m_f = 1; m_c = 2'd1; return; end
      if (l < 2) base = pte[31:13];
      else if (wr && !pte[1]) begin m_f = 1; m_c = 2'd2; end
      else m_pa = {pte[31:13], va[12:0]};
    end
  endtask

  task automatic chk(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [39:0] va, input logic wr);
    int n0;
    n0 = nrd;
    @(negedge clk_i);
    vaddr_i = va; write_i = wr; req_i = 1'b1; r_cyc = 0;
    do begin @(negedge clk_i); r_cyc++; end while (!ack_o && r_cyc < 1000);
    chk("R11 ack seen", ack_o, ack_o, 1);
    r_f = fault_o; r_c = cause_o; r_pa = paddr_o; r_n = nrd - n0;
    req_i = 1'b0;
    @(negedge clk_i);
    chk("R11 ack single pulse", !ack_o, ack_o, 0);
  endtask

  task automatic xcheck(input logic [39:0] va, input logic wr, input string tag);
    model(va, wr);
    xlate(va, wr);
    chk({tag, " fault"}, r_f == m_f, r_f, m_f);
    chk({tag, " cause"}, r_c == m_c, r_c, m_c);
    if (!m_f) chk({tag, " paddr R1"}, r_pa == m_pa, r_pa, m_pa);
  endtask

  task automatic pulse_flush();
    @(negedge clk_i); flush_i = 1'b1;
    @(negedge clk_i); flush_i = 1'b0;
  endtask

  // table memory: random 1..3 cycle latency
  initial begin
    mem_valid_i = 1'b0; mem_rdata_i = '0;
    forever begin
      @(negedge clk_i);
      mem_valid_i = 1'b0;
      if (rst_ni === 1'b1 && mem_req_o) begin
        resp_a = mem_addr_o;
        rd_log[nrd % 16] = resp_a;
        nrd++;
        repeat (1 + $urandom_range(2)) @(negedge clk_i);
        if (mem_req_o) chk("R3 second read while outstanding", 0, 1, 0);
        mem_rdata_i = pte_of(resp_a);
        mem_valid_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL R11 watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_ni = 1'b0; flush_i = 1'b0; req_i = 1'b0; vaddr_i = '0; write_i = 1'b0;
    root_frame_i = 19'h2B4C1;
    clean = 1; inv_a = 32'h1; ro_a0 = 32'h1; ro_a1 = 32'h1;
    repeat (3) @(negedge clk_i);
    chk("R10 reset ack", ack_o == 0, ack_o, 0);
    chk("R10 reset fault", fault_o == 0, fault_o, 0);
    chk("R10 reset mem_req", mem_req_o == 0, mem_req_o, 0);
    rst_ni = 1'b1;

    // R2 walk addresses and R1 offset on a miss
    xcheck(pg(1, 13'h0ABC), 0, "R2 first walk");
    chk("R2 three reads", r_n == 3, r_n, 3);
    for (int l = 0; l < 3; l++)
      chk("R2 read address", rd_log[(nrd - 3 + l) % 16] == m_a[l], rd_log[(nrd - 3 + l) % 16], m_a[l]);
    chk("R11 cause zero on success", r_c == 0, r_c, 0);

    // R6 hit: no reads, two-cycle acknowledge
    xcheck(pg(1, 13'h1FFF), 1, "R6 hit");
    chk("R6 no reads on hit", r_n == 0, r_n, 0);
    chk("R6 hit latency", r_cyc == 2, r_cyc, 2);

    // R4 invalid middle entry, R7 retried walk
    model(pg(2, 0), 0); inv_a = m_a[1];
    xcheck(pg(2, 5), 0, "R4 invalid level1");
    chk("R4 walk stops after two reads", r_n == 2, r_n, 2);
    xcheck(pg(2, 6), 0, "R7 fault not cached");
    chk("R7 invalid walk repeated", r_n == 2, r_n, 2);

    // R12 read-only leaf cached from a read
    model(pg(3, 0), 0); ro_a1 = m_a[2];
    xcheck(pg(3, 7), 0, "R12 read of read-only page");
    xcheck(pg(3, 8), 1, "R12 write hits read-only entry");
    chk("R12 no reads", r_n == 0, r_n, 0);

    // R5 write denied on walk, R7 not filled, upper write bit ignored
    model(pg(4, 0), 0); ro_a1 = m_a[2];
    xcheck(pg(4, 9), 1, "R5 write denied");
    chk("R5 cause two", r_c == 2, r_c, 2);
    xcheck(pg(4, 9), 0, "R5 read allowed");
    chk("R7 denied walk not cached", r_n == 3, r_n, 3);
    model(pg(5, 0), 0); ro_a0 = m_a[0];
    xcheck(pg(5, 3), 1, "R5 upper write bit ignored");

    // R9 flush
    xlate(pg(1, 1), 0);
    chk("R9 page cached before flush", r_n == 0, r_n, 0);
    pulse_flush();
    xcheck(pg(1, 2), 0, "R9 after flush");
    chk("R9 walk after flush", r_n == 3, r_n, 3);

    // R8 round robin
    pulse_flush();
    for (int k = 10; k < 18; k++) begin
      xlate(pg(k, k), 0);
      chk("R8 fill", r_n == 3, r_n, 3);
    end
    for (int k = 10; k < 18; k++) begin
      xlate(pg(k, k), 0);
      chk("R8 eight resident", r_n == 0, r_n, 0);
    end
    xlate(pg(18, 0), 0);
    chk("R8 ninth fill", r_n == 3, r_n, 3);
    for (int k = 11; k < 19; k++) begin
      xlate(pg(k, 1), 0);
      chk("R8 survivors hit", r_n == 0, r_n, 0);
    end
    xcheck(pg(10, 4), 0, "R8 oldest evicted");
    chk("R8 oldest walks again", r_n == 3, r_n, 3);

    // random tables, addresses and access types
    clean = 0;
    pulse_flush();
    for (int i = 0; i < 400; i++) begin
      logic [39:0] va;
      if ($urandom_range(7) == 0) va = {$urandom, $urandom};
      else va = pg(40 + $urandom_range(15), $urandom);
      if ($urandom_range(40) == 0) pulse_flush();
      xcheck(va, 1'($urandom_range(1)), "R1 R4 R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule